// File: doc/BRIEF.md
# Serially Configured Six-Input Lookup Table

This block is the logic element of a programmable tile. It holds a 64-entry truth table, one bit per cell, and a single 6-bit selector addresses those cells. The selector is shared. During configuration a controller uses it to write cells. During evaluation the six logic inputs use it to read them. Truth-table bits arrive one at a time on a serial input while a shift qualifier is high. The host normally sends them in bursts of eight, with idle cycles between bursts.

A policy input selects when shifted bits reach the cell array, which stands for the persistent storage.
- In write-through mode each bit is committed one cycle after it is shifted.
- In staged mode, bits collect in a volatile staging register. They are committed to the cells, one per cycle, only after a power-off request. The block then acknowledges the request.

The cell array has no reset. A reset clears every other register and leaves the loaded function intact.

Top module: `shiftcfg_lut`

## Requirements
- R1: After reset, `lut_out`, `cfg_done` and `pwr_off_ack` are 0.
- R2: With `stage_mode` = 0, the n-th bit shifted in after a `cfg_start` pulse is written to cell n, counting from 0. The write happens one cycle after the shift.
- R3: When `rd_en` is 1 and the selector is not busy with a write or shift, `lut_out` shows cell `lut_in` one clock edge later. Bit i of `lut_in` is bit i of the cell index.
- R4: When `rd_en` is 0, `lut_out` keeps its value whatever `lut_in` does.
- R5: In any cycle with `shift_en` or an internal cell write, the selector carries the write address and the read is suppressed, so `lut_out` holds.
- R6: `cfg_done` is 0 while fewer than 64 cells have been written since `cfg_start`. It rises in the cycle after cell 63 is written, and `cfg_start` clears it.
- R7: With `stage_mode` = 1, shifted bits do not change any cell until `pwr_off_req` is raised.
- R8: `pwr_off_req` must be held high until `pwr_off_ack` is seen. Once the request is raised, every shifted but uncommitted bit is written, one per cycle. After that, `pwr_off_ack` rises and stays high until the cycle after the request falls.
- R9: Cell contents survive a reset, and reads after the reset return the table loaded before it.
- R10: Shifts beyond the 64th bit of a configuration pass are ignored, and so are shifts made while a power-off request is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the cells are not reset |
| cfg_start | input | 1 | Restarts the configuration pass at cell 0 |
| shift_en | input | 1 | Qualifies `shift_in` |
| shift_in | input | 1 | Serial truth-table bit |
| stage_mode | input | 1 | 0: write-through, 1: commit on power-off |
| pwr_off_req | input | 1 | Power-off request |
| pwr_off_ack | output | 1 | All shifted bits are committed |
| rd_en | input | 1 | Evaluation enable |
| lut_in | input | 6 | Logic inputs (cell index) |
| lut_out | output | 1 | Registered table output |
| cfg_done | output | 1 | All 64 cells written in this pass |

## Verification
A read driven before clock edge E is due on `lut_out` right after E. The scoreboard queues the expected bit when it drives the read, and compares it at the falling edge that follows E.

In write-through mode a shifted bit reaches its cell one edge after the shift. The bench therefore leaves idle cycles after the last shift before it starts any read.

In staged mode the drain after a power-off request takes one cycle per pending bit. The bench waits for the acknowledge with a bounded counter, so the drain time is not hard-coded.

The bench samples `cfg_done` and the acknowledge at falling edges once their triggering writes or request changes have settled.

// File: rtl/lutcfg_pkg.sv
package lutcfg_pkg;
    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_DRAIN = 2'd1,
        PM_HOLD  = 2'd2
    } pm_state_e;
endpackage

// File: rtl/lutcfg_ctrl.sv
module lutcfg_ctrl
    import lutcfg_pkg::*;
#(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             shift_en,
    input  logic             shift_in,
    input  logic             stage_mode,
    input  logic             pwr_off_req,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_addr,
    output logic             wr_bit,
    output logic             pwr_off_ack,
    output logic             cfg_done
);
    localparam int CELLS = 1 << SEL_W;
    localparam int CNT_W = SEL_W + 1;

    typedef struct packed {
        pm_state_e        st;
        logic [CELLS-1:0] stage;
        logic [CNT_W-1:0] cnt;   // bits shifted in this pass
        logic [CNT_W-1:0] addr;  // next cell to commit
        logic             done;
    } ctrl_t;

    ctrl_t q, d;
    logic  pending;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        pending = (q.addr < q.cnt);
        unique case (q.st)
            PM_IDLE: begin
                if (pwr_off_req) begin
                    d.st = PM_DRAIN;
                end else if (cfg_start) begin
                    d.cnt  = '0;
                    d.addr = '0;
                    d.done = 1'b0;
                end else begin
                    if (shift_en && (q.cnt < CNT_W'(CELLS))) begin
                        d.stage[q.cnt[SEL_W-1:0]] = shift_in;
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (!stage_mode && pending) wr_en = 1'b1;
                end
            end
            PM_DRAIN: begin
                if (pending) wr_en = 1'b1;
                else         d.st  = PM_HOLD;
            end
            PM_HOLD: begin
                if (!pwr_off_req) d.st = PM_IDLE;
            end
            default: d.st = PM_IDLE;
        endcase
        if (wr_en) begin
            d.addr = q.addr + 1'b1;
            if (q.addr == CNT_W'(CELLS - 1)) d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: PM_IDLE, stage: '0, cnt: '0, addr: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_addr     = q.addr[SEL_W-1:0];
    assign wr_bit      = q.stage[q.addr[SEL_W-1:0]];
    assign pwr_off_ack = (q.st == PM_HOLD);
    assign cfg_done    = q.done;
endmodule

// File: rtl/lutcfg_selmux.sv
module lutcfg_selmux #(
    parameter int SEL_W = 6
) (
    input  logic [SEL_W-1:0] x_addr,
    input  logic [SEL_W-1:0] y_in,
    input  logic             use_x,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = use_x ? x_addr : y_in;
    end
endmodule

// File: rtl/lutcfg_cells.sv
module lutcfg_cells #(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_ok,
    output logic             rd_q
);
    localparam int CELLS = 1 << SEL_W;

    logic [CELLS-1:0] mem;   // persistent: no reset
    logic             out_d, out_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[sel] <= wr_bit;
    end

    always_comb begin
        out_d = rd_ok ? mem[sel] : out_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign rd_q = out_q;
endmodule

// File: rtl/shiftcfg_lut.sv
module shiftcfg_lut #(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             shift_en,
    input  logic             shift_in,
    input  logic             stage_mode,
    input  logic             pwr_off_req,
    output logic             pwr_off_ack,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] lut_in,
    output logic             lut_out,
    output logic             cfg_done
);
    logic             wr_en;
    logic [SEL_W-1:0] wr_addr;
    logic             wr_bit;
    logic [SEL_W-1:0] sel;
    logic             use_x;
    logic             rd_ok;

    lutcfg_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .shift_en(shift_en), .shift_in(shift_in), .stage_mode(stage_mode),
        .pwr_off_req(pwr_off_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .pwr_off_ack(pwr_off_ack), .cfg_done(cfg_done)
    );

    assign use_x = shift_en | wr_en;
    assign rd_ok = rd_en & ~use_x;

    lutcfg_selmux #(.SEL_W(SEL_W)) u_sel (
        .x_addr(wr_addr), .y_in(lut_in), .use_x(use_x), .sel(sel)
    );

    lutcfg_cells #(.SEL_W(SEL_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .wr_bit(wr_bit), .rd_ok(rd_ok), .rd_q(lut_out)
    );
endmodule

// File: rtl/lutcfg_chk.sv
module lutcfg_chk #(
    parameter int SEL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic             stage_mode,
    input logic             pwr_off_req,
    input logic             pwr_off_ack,
    input logic             rd_en,
    input logic             lut_out,
    input logic             cfg_done,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_addr
);
    localparam int CELLS = 1 << SEL_W;

    p_idle_read_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(lut_out));

    p_write_blocks_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(lut_out));

    p_shift_blocks_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> $stable(lut_out));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(wr_en && (wr_addr == SEL_W'(CELLS - 1))));

    p_staged_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_mode && wr_en) |-> pwr_off_req);

    p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off_ack) |-> pwr_off_req);

    p_no_write_at_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_ack |-> !wr_en);
endmodule

bind shiftcfg_lut lutcfg_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .stage_mode(stage_mode),
    .pwr_off_req(pwr_off_req), .pwr_off_ack(pwr_off_ack), .rd_en(rd_en),
    .lut_out(lut_out), .cfg_done(cfg_done), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tb_shiftcfg_lut.sv
`timescale 1ns/1ps
module tb_shiftcfg_lut;
    localparam int SEL_W = 6;
    localparam int CELLS = 1 << SEL_W;
    localparam int BURST = 8;

    logic clk = 1'b0;
    logic rst_n, cfg_start, shift_en, shift_in, stage_mode, pwr_off_req, rd_en;
    logic [SEL_W-1:0] lut_in;
    logic pwr_off_ack, lut_out, cfg_done;

    int errs = 0;
    int checks = 0;
    logic  exp_q[$];
    string tag_q[$];
    int    idx_q[$];
    logic  due = 1'b0;
    logic [CELLS-1:0] t1, t2;

    always #2.5 clk = ~clk;

    shiftcfg_lut #(.SEL_W(SEL_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .shift_en(shift_en),
        .shift_in(shift_in), .stage_mode(stage_mode), .pwr_off_req(pwr_off_req),
        .pwr_off_ack(pwr_off_ack), .rd_en(rd_en), .lut_in(lut_in),
        .lut_out(lut_out), .cfg_done(cfg_done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: a read driven before an edge is due right after that edge
    always @(posedge clk) due <= rd_en && !shift_en;
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            logic  e;
            string t;
            int    i;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            i = idx_q.pop_front();
            checks++;
            if (lut_out !== e) begin
                errs++;
                $display("FAIL %s: cell %0d actual=%0d expected=%0d", t, i, lut_out, e);
            end
        end
    end

    task automatic read_all(input logic [CELLS-1:0] tbl, input string tag);
        for (int i = 0; i < CELLS; i++) begin
            @(negedge clk);
            lut_in = SEL_W'(i);
            rd_en  = 1'b1;
            exp_q.push_back(tbl[i]);
            tag_q.push_back(tag);
            idx_q.push_back(i);
        end
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); cfg_start = 1'b1;
        @(negedge clk); cfg_start = 1'b0;
    endtask

    task automatic shift_table(input logic [CELLS-1:0] tbl, input bit check_first);
        for (int b = 0; b < CELLS / BURST; b++) begin
            for (int i = 0; i < BURST; i++) begin
                @(negedge clk);
                shift_en = 1'b1;
                shift_in = tbl[b*BURST + i];
            end
            @(negedge clk); shift_en = 1'b0;
            @(negedge clk); @(negedge clk);
            if (check_first && b == 0)
                chk(cfg_done == 1'b0, "R6 done early", cfg_done, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic power_off(input string tag);
        int n;
        n = 0;
        @(negedge clk); pwr_off_req = 1'b1;
        while (!pwr_off_ack && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(pwr_off_ack == 1'b1, tag, pwr_off_ack, 1);
        @(negedge clk); pwr_off_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(pwr_off_ack == 1'b0, "R8 ack release", pwr_off_ack, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic held;
        rst_n = 1'b0; cfg_start = 1'b0; shift_en = 1'b0; shift_in = 1'b0;
        stage_mode = 1'b0; pwr_off_req = 1'b0; rd_en = 1'b0; lut_in = '0;
        t1 = {$urandom(32'h51ab), $urandom};
        t2 = {$urandom, $urandom};
        if (t2 == t1) t2 = ~t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lut_out == 1'b0, "R1 out", lut_out, 0);
        chk(cfg_done == 1'b0, "R1 done", cfg_done, 0);
        chk(pwr_off_ack == 1'b0, "R1 ack", pwr_off_ack, 0);

        // write-through load
        pulse_start();
        shift_table(t1, 1'b1);
        chk(cfg_done == 1'b1, "R6 done set", cfg_done, 1);
        // extra bits after 64: must be ignored (R10)
        for (int i = 0; i < BURST; i++) begin
            @(negedge clk); shift_en = 1'b1; shift_in = ~t1[i];
        end
        @(negedge clk); shift_en = 1'b0;
        repeat (3) @(negedge clk);
        read_all(t1, "R2/R3/R10 write-through");
        power_off("R8 ack write-through");

        // staged load
        stage_mode = 1'b1;
        pulse_start();
        chk(cfg_done == 1'b0, "R6 start clears", cfg_done, 0);
        shift_table(t2, 1'b0);
        chk(cfg_done == 1'b0, "R7 no commit", cfg_done, 0);
        read_all(t1, "R7 staged uncommitted");
        power_off("R8 ack after drain");
        chk(cfg_done == 1'b1, "R8 drain done", cfg_done, 1);
        read_all(t2, "R8 committed");

        // retention
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(lut_out == 1'b0, "R1 out after reset", lut_out, 0);
        chk(cfg_done == 1'b0, "R1 done after reset", cfg_done, 0);
        read_all(t2, "R9 retention");

        // R4: rd_en low holds
        begin
            int a, b;
            a = 0;
            b = 0;
            for (int i = 1; i < CELLS; i++) if (t2[i] != t2[0]) b = i;
            @(negedge clk); lut_in = SEL_W'(a); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
            held = lut_out;
            chk(held == t2[a], "R3 direct read", held, t2[a]);
            lut_in = SEL_W'(b);
            @(negedge clk); @(negedge clk);
            chk(lut_out == held, "R4 hold", lut_out, held);
            // R5: read with shift active is suppressed (staged mode: no write)
            @(negedge clk); lut_in = SEL_W'(b); rd_en = 1'b1; shift_en = 1'b1; shift_in = 1'b0;
            @(negedge clk); rd_en = 1'b0; shift_en = 1'b0;
            chk(lut_out == held, "R5 shift blocks read", lut_out, held);
        end

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule